// File: doc/BRIEF.md
# One-Time-Programmable Code Memory Controller

This block models an on-chip code store that can be programmed once. It also contains the controller that grants or refuses access to it. A programming port takes byte addresses, data and strobes, and it has a flag that reports whether the programming supply is present. Through this port the byte array and two protected configuration bytes can be programmed and read back. A second port serves the running processor, returning 16-bit instruction words from the same array. Programming can only clear bits. Only the separate erase input, which stands in for a bulk ultraviolet erase, returns the contents to all ones.

The two configuration bytes sit outside the array's address space. A configuration byte is written only when two things agree: a pointer loaded beforehand, and the index presented with the write strobe. The two low bits of configuration byte 7 hold the protection level. Each lower level shuts off one more kind of access.

A select input chooses between on-chip and off-chip program memory. The block samples it during reset and holds it until the next reset. At full size the array holds 16 kbytes (`ADDR_W` = 14). The default parameter is smaller so that elaboration stays light.

Top module: `otp_prog_ctrl`

## Requirements
- R1: When `erase_all` is high at a clock edge, every array byte and both configuration bytes become 8'hFF, whatever the other inputs are doing.
- R2: An accepted array program changes the stored byte to the old value ANDed with `pv_wdata`. A 1 in the data leaves that bit as it was.
- R3: A program strobe takes effect only while `hv_present` is high. Programming-port reads return data whether `hv_present` is high or low.
- R4: With `pv_space` = 1, `pv_addr[2:0]` selects a configuration byte (6 or 7). The byte is programmed only when the pointer loaded by `pv_ptr_wr` (from `pv_wdata[2:0]`) equals that index. Any other write is dropped.
- R5: Configuration bytes are separate from the array. Array writes never change them, and configuration writes never change array bytes 6 and 7.
- R6: The protection level is configuration byte 7 bits [1:0]. Level 3 (2'b11) permits everything. At level 2 (2'b10), programming-port writes to the array and to both configuration bytes are ignored, so the level cannot be changed again until an erase.
- R7: At levels 1 (2'b01) and 0 (2'b00), programming-port reads return 8'hFF.
- R8: At level 0, run-mode fetches return 16'hFFFF. At levels 1 to 3, fetches return the stored data.
- R9: A run-mode fetch of word `w` returns `{byte[2w+1], byte[2w]}` with `fetch_valid` high on the cycle after `fetch_req`.
- R10: `ext_mem_latched` takes the value of `ext_mem_sel` from the last clock of reset and then holds it. While it is 1, fetches produce no `fetch_valid`.
- R11: `pv_rvalid` rises on the cycle after a read strobe in programming mode (`pgm_mode` = 1). Programming-port strobes are ignored in run mode, and fetch requests are ignored in programming mode.
- R12: After reset, `pv_rvalid` and `fetch_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| erase_all | input | 1 | Test-only bulk erase to all ones |
| pgm_mode | input | 1 | 1 = programming mode, 0 = run mode |
| hv_present | input | 1 | Programming supply present |
| pv_space | input | 1 | 0 = array, 1 = configuration bytes |
| pv_addr | input | ADDR_W | Byte address, or configuration index in bits [2:0] |
| pv_wdata | input | 8 | Program data, or pointer value in bits [2:0] |
| pv_prog | input | 1 | Program strobe |
| pv_read | input | 1 | Read strobe |
| pv_ptr_wr | input | 1 | Load configuration pointer |
| ext_mem_sel | input | 1 | Off-chip program memory select, sampled in reset |
| fetch_req | input | 1 | Run-mode fetch request |
| fetch_waddr | input | ADDR_W-1 | Run-mode word address |
| pv_rdata | output | 8 | Read data |
| pv_rvalid | output | 1 | Read data valid |
| fetch_data | output | 16 | Fetched word |
| fetch_valid | output | 1 | Fetched word valid |
| ext_mem_latched | output | 1 | Held memory select |

## Verification
The hardest states to reach are the protection levels below 3. Level 2 blocks every further write, so levels 1 and 0 cannot be reached from it and can be entered only straight from an erased part. The stimulus therefore erases, programs chosen array bytes while the part is still open, and then takes configuration byte 7 down to the target level in a single pointer-matched write. Each level gets a fresh erase. The off-chip select case calls for a second reset with the select held high, after which the input is dropped to show that it is ignored.

// File: rtl/otp_pkg.sv
// Shared types for the one-time-programmable memory controller.
// Assumes configuration indices are 3 bits wide.
package otp_pkg;
    localparam int CFG_IDX_W = 3;
    localparam logic [CFG_IDX_W-1:0] CFG_IDX_LO = 3'd6;
    localparam logic [CFG_IDX_W-1:0] CFG_IDX_HI = 3'd7;

    typedef enum logic [1:0] {
        SEC_L0   = 2'b00,
        SEC_L1   = 2'b01,
        SEC_L2   = 2'b10,
        SEC_OPEN = 2'b11
    } sec_lvl_e;

    typedef struct packed {
        logic pgm_wr_ok;
        logic pgm_rd_ok;
        logic run_rd_ok;
    } access_t;
endpackage

// File: rtl/otp_array.sv
// Byte array that can be programmed once. A program ANDs the data into
// the stored byte. Erase sets every byte to ones and has priority.
// It has one byte read port and one 16-bit word read port (low byte at
// the even address). Contents are non-volatile, so reset does not touch them.
module otp_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    input  logic [ADDR_W-2:0] word_addr,
    output logic [15:0]       word_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Bulk erase, or clear the bits that the presented data has at 0.
    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_byte   = mem[rd_addr];
        word_data = {mem[{word_addr, 1'b1}], mem[{word_addr, 1'b0}]};
    end
endmodule

// File: rtl/otp_cfg_regs.sv
// Two protected configuration bytes and their pointer register.
// A write lands only when the pointer equals the presented index and the
// index names one of the two bytes. The caller gates wr_en for mode,
// supply and protection level. Byte 7 bits [1:0] give the protection level.
module otp_cfg_regs
    import otp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 erase,
    input  logic                 ptr_wr,
    input  logic [CFG_IDX_W-1:0] ptr_val,
    input  logic                 wr_en,
    input  logic [CFG_IDX_W-1:0] idx,
    input  logic [7:0]           wr_data,
    output logic [7:0]           rd_byte,
    output logic [CFG_IDX_W-1:0] ptr,
    output logic [7:0]           cfg_lo,
    output logic [7:0]           cfg_hi,
    output logic [1:0]           sec_level
);
    logic hit;

    // Pointer register, cleared to an index that names no byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (ptr_wr) ptr <= ptr_val;
    end

    assign hit = wr_en && (ptr == idx);

    // Configuration bytes: erased to ones, programmed only on a pointer match.
    always_ff @(posedge clk) begin
        if (erase) begin
            cfg_lo <= 8'hFF;
            cfg_hi <= 8'hFF;
        end else if (hit && idx == CFG_IDX_LO) begin
            cfg_lo <= cfg_lo & wr_data;
        end else if (hit && idx == CFG_IDX_HI) begin
            cfg_hi <= cfg_hi & wr_data;
        end
    end

    // Read selection; an index that names neither byte reads ones.
    always_comb begin
        unique case (idx)
            CFG_IDX_LO: rd_byte = cfg_lo;
            CFG_IDX_HI: rd_byte = cfg_hi;
            default:    rd_byte = 8'hFF;
        endcase
    end

    assign sec_level = cfg_hi[1:0];
endmodule

// File: rtl/otp_access_gate.sv
// Decodes the protection level into access permissions. Purely
// combinational, with no state of its own.
module otp_access_gate
    import otp_pkg::*;
(
    input  logic [1:0] sec_level,
    output access_t    acc
);
    sec_lvl_e lvl;

    // Each step down removes one more class of access.
    always_comb begin
        lvl           = sec_lvl_e'(sec_level);
        acc.pgm_wr_ok = (lvl == SEC_OPEN);
        acc.pgm_rd_ok = (lvl == SEC_OPEN) || (lvl == SEC_L2);
        acc.run_rd_ok = (lvl != SEC_L0);
    end
endmodule

// File: rtl/otp_prog_ctrl.sv
// Top of the one-time-programmable code memory controller. It joins the
// array, the configuration bytes and the access decode to the programming
// port and the run-mode fetch port. Read results are registered and valid
// one cycle after the strobe. The on/off-chip memory select is captured
// on every clock while reset is low.
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_all,
    input  logic              pgm_mode,
    input  logic              hv_present,
    input  logic              pv_space,
    input  logic [ADDR_W-1:0] pv_addr,
    input  logic [7:0]        pv_wdata,
    input  logic              pv_prog,
    input  logic              pv_read,
    input  logic              pv_ptr_wr,
    input  logic              ext_mem_sel,
    input  logic              fetch_req,
    input  logic [ADDR_W-2:0] fetch_waddr,
    output logic [7:0]        pv_rdata,
    output logic              pv_rvalid,
    output logic [15:0]       fetch_data,
    output logic              fetch_valid,
    output logic              ext_mem_latched
);
    access_t              acc;
    logic [1:0]           sec_level;
    logic [CFG_IDX_W-1:0] cfg_ptr;
    logic [7:0]           cfg_lo, cfg_hi;
    logic [7:0]           arr_rd, cfg_rd;
    logic [15:0]          arr_word;
    logic                 prog_ok, rd_go, fetch_go;

    // Qualify the strobes with mode, supply and protection level.
    always_comb begin
        prog_ok  = pgm_mode && hv_present && pv_prog && acc.pgm_wr_ok;
        rd_go    = pgm_mode && pv_read;
        fetch_go = !pgm_mode && fetch_req && !ext_mem_latched;
    end

    otp_array #(.ADDR_W(ADDR_W)) array_i (
        .clk       (clk),
        .erase     (erase_all),
        .wr_en     (prog_ok && !pv_space),
        .wr_addr   (pv_addr),
        .wr_data   (pv_wdata),
        .rd_addr   (pv_addr),
        .rd_byte   (arr_rd),
        .word_addr (fetch_waddr),
        .word_data (arr_word)
    );

    otp_cfg_regs cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase     (erase_all),
        .ptr_wr    (pgm_mode && pv_ptr_wr),
        .ptr_val   (pv_wdata[CFG_IDX_W-1:0]),
        .wr_en     (prog_ok && pv_space),
        .idx       (pv_addr[CFG_IDX_W-1:0]),
        .wr_data   (pv_wdata),
        .rd_byte   (cfg_rd),
        .ptr       (cfg_ptr),
        .cfg_lo    (cfg_lo),
        .cfg_hi    (cfg_hi),
        .sec_level (sec_level)
    );

    otp_access_gate gate_i (
        .sec_level (sec_level),
        .acc       (acc)
    );

    // Registered read, fetch and memory-select outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_rvalid       <= 1'b0;
            pv_rdata        <= 8'hFF;
            fetch_valid     <= 1'b0;
            fetch_data      <= 16'hFFFF;
            ext_mem_latched <= ext_mem_sel;
        end else begin
            pv_rvalid   <= rd_go;
            fetch_valid <= fetch_go;
            if (rd_go)
                pv_rdata <= !acc.pgm_rd_ok ? 8'hFF : (pv_space ? cfg_rd : arr_rd);
            if (fetch_go)
                fetch_data <= acc.run_rd_ok ? arr_word : 16'hFFFF;
        end
    end
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
// Temporal checks on the controller, bound into every instance of the top.
// It only observes and drives nothing.
module otp_prog_ctrl_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              erase_all,
    input logic              pgm_mode,
    input logic              hv_present,
    input logic              pv_space,
    input logic [ADDR_W-1:0] pv_addr,
    input logic              pv_prog,
    input logic              pv_read,
    input logic [7:0]        pv_rdata,
    input logic              pv_rvalid,
    input logic              fetch_req,
    input logic [15:0]       fetch_data,
    input logic              fetch_valid,
    input logic              ext_mem_latched,
    input logic [1:0]        sec_level,
    input logic [2:0]        cfg_ptr,
    input logic [7:0]        cfg_lo,
    input logic [7:0]        cfg_hi
);
    // Read strobe in programming mode yields a valid one cycle later (R11).
    p_rvalid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_mode && pv_read) |=> pv_rvalid);

    // No valid without a qualifying strobe (R11).
    p_no_stray_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_mode && pv_read) |=> !pv_rvalid);

    // Locked programming reads return ones (R7).
    p_locked_read_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_mode && pv_read && !sec_level[1]) |=> (pv_rdata == 8'hFF));

    // Level 0 blanks run-mode fetches (R8).
    p_level0_fetch_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_mode && fetch_req && sec_level == 2'b00 && !ext_mem_latched)
        |=> (fetch_valid && fetch_data == 16'hFFFF));

    // Off-chip select suppresses fetch valids (R10).
    p_ext_no_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mem_latched |=> !fetch_valid);

    // A configuration write with a mismatched pointer changes nothing (R4).
    p_ptr_mismatch_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_mode && hv_present && pv_prog && pv_space && !erase_all
         && pv_addr[2:0] != cfg_ptr) |=> ($stable(cfg_lo) && $stable(cfg_hi)));

    // Without erase the protection level only drops bits (R6).
    p_sec_only_tightens_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_all |=> ((sec_level & ~$past(sec_level)) == 2'b00));
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .erase_all       (erase_all),
    .pgm_mode        (pgm_mode),
    .hv_present      (hv_present),
    .pv_space        (pv_space),
    .pv_addr         (pv_addr),
    .pv_prog         (pv_prog),
    .pv_read         (pv_read),
    .pv_rdata        (pv_rdata),
    .pv_rvalid       (pv_rvalid),
    .fetch_req       (fetch_req),
    .fetch_data      (fetch_data),
    .fetch_valid     (fetch_valid),
    .ext_mem_latched (ext_mem_latched),
    .sec_level       (sec_level),
    .cfg_ptr         (cfg_ptr),
    .cfg_lo          (cfg_lo),
    .cfg_hi          (cfg_hi)
);

// File: tb/otp_prog_ctrl_tb.sv
// Sweeps a 64-byte array against a model of plain AND arithmetic.
module otp_prog_ctrl_tb_top;
    localparam int AW = 6;
    localparam int NB = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0, erase_all = 1'b0, pgm_mode = 1'b0, hv_present = 1'b0;
    logic pv_space = 1'b0, pv_prog = 1'b0, pv_read = 1'b0, pv_ptr_wr = 1'b0;
    logic ext_mem_sel = 1'b0, fetch_req = 1'b0;
    logic [AW-1:0] pv_addr = '0;
    logic [AW-2:0] fetch_waddr = '0;
    logic [7:0] pv_wdata = '0, pv_rdata;
    logic [15:0] fetch_data;
    logic pv_rvalid, fetch_valid, ext_mem_latched;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [7:0] model [NB];

    always #4 clk = ~clk;

    otp_prog_ctrl #(.ADDR_W(AW)) dut_i (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic prog(logic sp, logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        pv_space = sp; pv_addr = a; pv_wdata = d; pv_prog = 1'b1;
        @(negedge clk);
        pv_prog = 1'b0;
    endtask

    task automatic set_ptr(logic [2:0] p);
        @(negedge clk);
        pv_wdata = {5'd0, p}; pv_ptr_wr = 1'b1;
        @(negedge clk);
        pv_ptr_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic sp, logic [AW-1:0] a, logic ev, logic [7:0] ed);
        @(negedge clk);
        pv_space = sp; pv_addr = a; pv_read = 1'b1;
        @(negedge clk);
        pv_read = 1'b0;
        chk({tag, " rvalid"}, {31'd0, pv_rvalid}, {31'd0, ev});
        if (ev) chk({tag, " rdata"}, {24'd0, pv_rdata}, {24'd0, ed});
    endtask

    task automatic fetch(string tag, logic [AW-2:0] w, logic ev, logic [15:0] ed);
        @(negedge clk);
        fetch_waddr = w; fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        chk({tag, " fvalid"}, {31'd0, fetch_valid}, {31'd0, ev});
        if (ev) chk({tag, " fdata"}, {16'd0, fetch_data}, {16'd0, ed});
    endtask

    task automatic erase();
        @(negedge clk);
        erase_all = 1'b1;
        @(negedge clk);
        erase_all = 1'b0;
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    endtask

    task automatic do_reset(logic ext);
        @(negedge clk);
        rst_n = 1'b0; ext_mem_sel = ext;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ext_mem_sel = ~ext;
    endtask

    initial begin
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
        erase_all = 1'b1;
        repeat (3) @(negedge clk);
        erase_all = 1'b0;
        rst_n = 1'b1;
        // R12: reset state
        chk("R12 rvalid", {31'd0, pv_rvalid}, 0);
        chk("R12 fvalid", {31'd0, fetch_valid}, 0);

        pgm_mode = 1'b1; hv_present = 1'b1;
        // R1: erased contents
        for (int a = 0; a < NB; a++) rd("R1 array", 1'b0, AW'(a), 1'b1, 8'hFF);
        rd("R1 cfg6", 1'b1, AW'(6), 1'b1, 8'hFF);
        rd("R1 cfg7", 1'b1, AW'(7), 1'b1, 8'hFF);

        // R2: two program passes, each ANDed into the model
        for (int a = 0; a < NB; a++) begin
            logic [7:0] d = 8'(a * 37) ^ 8'h5A;
            prog(1'b0, AW'(a), d); model[a] &= d;
        end
        for (int a = 0; a < NB; a++) begin
            logic [7:0] d = ~8'(a * 11);
            prog(1'b0, AW'(a), d); model[a] &= d;
        end
        for (int a = 0; a < NB; a++) rd("R2 and", 1'b0, AW'(a), 1'b1, model[a]);

        // R9: fetch every word in run mode
        pgm_mode = 1'b0;
        for (int w = 0; w < NB / 2; w++)
            fetch("R9 word", (AW-1)'(w), 1'b1, {model[2*w+1], model[2*w]});

        // R11: programming strobes ignored in run mode
        prog(1'b0, AW'(0), 8'h00);
        rd("R11 run read", 1'b0, AW'(0), 1'b0, 8'h00);
        pgm_mode = 1'b1;
        fetch("R11 pgm fetch", '0, 1'b0, 16'h0);
        rd("R11 unchanged", 1'b0, AW'(0), 1'b1, model[0]);

        // R3: no supply, no program; reads still served
        hv_present = 1'b0;
        prog(1'b0, AW'(1), 8'h00);
        rd("R3 read no hv", 1'b0, AW'(1), 1'b1, model[1]);
        hv_present = 1'b1;

        // R4: pointer must match presented index
        set_ptr(3'd6);
        prog(1'b1, AW'(7), 8'h00);
        rd("R4 mismatch", 1'b1, AW'(7), 1'b1, 8'hFF);
        prog(1'b1, AW'(6), 8'h3C);
        rd("R4 cfg6", 1'b1, AW'(6), 1'b1, 8'h3C);
        set_ptr(3'd7);
        prog(1'b1, AW'(7), 8'hA7);
        rd("R4 cfg7", 1'b1, AW'(7), 1'b1, 8'hA7);

        // R5: array bytes 6 and 7 untouched by config writes
        rd("R5 arr6", 1'b0, AW'(6), 1'b1, model[6]);
        rd("R5 arr7", 1'b0, AW'(7), 1'b1, model[7]);

        // R6: level 2 blocks writes, including to the level itself
        prog(1'b1, AW'(7), 8'hA6);
        rd("R6 cfg7 lvl2", 1'b1, AW'(7), 1'b1, 8'hA6);
        prog(1'b0, AW'(2), 8'h00);
        rd("R6 array locked", 1'b0, AW'(2), 1'b1, model[2]);
        prog(1'b1, AW'(7), 8'h00);
        rd("R6 cfg7 locked", 1'b1, AW'(7), 1'b1, 8'hA6);
        set_ptr(3'd6);
        prog(1'b1, AW'(6), 8'h00);
        rd("R6 cfg6 locked", 1'b1, AW'(6), 1'b1, 8'h3C);

        // R7: level 1 blanks programming reads but allows fetches
        erase();
        rd("R1 after erase", 1'b0, AW'(2), 1'b1, 8'hFF);
        prog(1'b0, AW'(3), 8'h12); model[3] = 8'h12;
        set_ptr(3'd7);
        prog(1'b1, AW'(7), 8'hFD);
        rd("R7 array blank", 1'b0, AW'(3), 1'b1, 8'hFF);
        rd("R7 cfg blank", 1'b1, AW'(7), 1'b1, 8'hFF);
        pgm_mode = 1'b0;
        fetch("R8 lvl1 fetch ok", (AW-1)'(1), 1'b1, {model[3], model[2]});

        // R8: level 0 blanks fetches
        pgm_mode = 1'b1;
        erase();
        prog(1'b0, AW'(8), 8'h34); model[8] = 8'h34;
        prog(1'b0, AW'(9), 8'h56); model[9] = 8'h56;
        pgm_mode = 1'b0;
        fetch("R8 before lock", (AW-1)'(4), 1'b1, 16'h5634);
        pgm_mode = 1'b1;
        prog(1'b1, AW'(7), 8'hFC);
        rd("R7 lvl0 read", 1'b0, AW'(8), 1'b1, 8'hFF);
        pgm_mode = 1'b0;
        fetch("R8 lvl0 fetch", (AW-1)'(4), 1'b1, 16'hFFFF);

        // R10: select captured in reset, later changes ignored
        do_reset(1'b1);
        @(negedge clk);
        chk("R10 latched", {31'd0, ext_mem_latched}, 1);
        fetch("R10 ext fetch", (AW-1)'(4), 1'b0, 16'h0);
        do_reset(1'b0);
        @(negedge clk);
        chk("R10 relatched", {31'd0, ext_mem_latched}, 0);
        fetch("R10 int fetch", (AW-1)'(4), 1'b1, 16'hFFFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule